// File: doc/BRIEF.md
# Framed Serial Packet Transmitter

This block turns one frame request into a stream of bytes for a downstream UART transmitter. A request carries a type byte, a payload length and up to `MAX_PAYLOAD` payload bytes on a flat vector. The transmitter captures the request while idle and sends the frame in this order: a fixed sync byte, the length, the type, the payload, and a trailing CRC-8. The CRC is built up one byte at a time as each byte is accepted downstream, so no pass over a stored frame is needed.

A packing option serves telemetry producers that hold 16-bit values in host order. The producer places each value as a little-endian pair in the payload vector. The block then swaps every byte pair on capture, so each multi-byte field leaves high byte first. Requests whose length exceeds the buffer are refused with a one-cycle error strobe and produce no bytes. Queuing of requests, baud timing and bit serialization belong to neighbouring blocks. `MAX_PAYLOAD` must be even and at least 2.

Top module: `pkt_frame_tx`

## Requirements
- R1: After reset, `tx_valid`, `busy` and `req_err` are 0 and `req_ready` is 1.
- R2: An accepted request with length N produces exactly N+4 bytes on `tx_data`, in this order: 0xAA, N, the type, payload bytes 0 to N-1, and the CRC. Payload byte i is taken from `req_payload[8*i+7:8*i]`.
- R3: The final byte is CRC-8 with polynomial 0x07 and initial value 0x00. It is shifted MSB first, with no reflection and no final XOR. It is computed over the length, the type and the payload bytes, and the sync byte is excluded.
- R4: A request with length 0 produces the four bytes 0xAA, 0x00, type, CRC.
- R5: A request seen while idle with length greater than `MAX_PAYLOAD` raises `req_err` for exactly one cycle, one cycle after it is presented. No byte is sent, and `busy` stays 0.
- R6: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` stays unchanged in the next cycle. Stalls of any length leave the frame contents and its CRC unchanged.
- R7: `busy` rises in the cycle after a request is accepted and falls in the cycle after the CRC byte is accepted. `req_ready` equals the inverse of `busy`. A request presented while busy is ignored: it does not alter the frame in flight and raises no error.
- R8: When `req_be16` is 1, payload byte i is taken from payload vector byte i XOR 1. Each little-endian 16-bit pair therefore goes out high byte first. With an odd length, the last byte sent is the high byte of the last pair.
- R9: A request with length exactly `MAX_PAYLOAD` is accepted and sent in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Transmitter idle; a request is taken this cycle |
| req_type | input | 8 | Frame type byte |
| req_len | input | 8 | Payload length in bytes |
| req_be16 | input | 1 | Swap byte pairs so 16-bit fields go out high byte first |
| req_payload | input | 8*MAX_PAYLOAD | Payload bytes; byte i at bits 8*i+7:8*i |
| req_err | output | 1 | One-cycle strobe: oversize request refused |
| busy | output | 1 | Frame in flight |
| tx_valid | output | 1 | Byte available downstream |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Byte to transmit |

## Verification
A wrong CRC accumulation, such as folding in the sync byte or updating during a stall, shows only in the last byte of a frame. Each frame's trailing byte is therefore compared with an independent model, with and without stalls. A miscounted payload index or length shows at once as a frame of the wrong byte count, or as a shifted payload, in the same frame. A stuck busy flag shows within one cycle of the CRC handshake, because `req_ready` would not return. A missed reject shows in the cycle after the oversize request, as either a missing error strobe or a sync byte that should not appear.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_LEN,
    ST_TYPE,
    ST_PAY,
    ST_CRC
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'hAA;
  localparam logic [7:0] CRC_POLY  = 8'h07;

  // one byte of MSB-first CRC-8, no reflection
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int b = 0; b < 8; b++) begin
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/pkt_crc8.sv
module pkt_crc8
  import pkt_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc_q,
  output logic [7:0] crc_nx
);

  assign crc_nx = crc8_step(crc_q, din);

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= 8'h00;
    else if (en)    crc_q <= crc_nx;
  end

  // R3: every frame starts its CRC from zero
  a_r3_crc_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc_q == 8'h00));

endmodule

// File: rtl/pkt_payload_buf.sv
module pkt_payload_buf #(
  parameter int MAX_BYTES = 16,
  localparam int IDXW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic                   be16,
  input  logic [8*MAX_BYTES-1:0] din,
  input  logic [IDXW-1:0]        rd_idx,
  output logic [7:0]             rd_byte
);

  logic [7:0] mem [MAX_BYTES];

  generate
    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_slot
      localparam int SWP = ((k ^ 1) < MAX_BYTES) ? (k ^ 1) : k;
      always_ff @(posedge clk) begin
        if (wr_en) mem[k] <= be16 ? din[8*SWP +: 8] : din[8*k +: 8];
      end
    end
  endgenerate

  assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/pkt_frame_tx.sv
module pkt_frame_tx
  import pkt_frame_pkg::*;
#(
  parameter int MAX_PAYLOAD = 16,
  localparam int IDXW = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1,
  localparam int LENW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [7:0]               req_type,
  input  logic [LENW-1:0]          req_len,
  input  logic                     req_be16,
  input  logic [8*MAX_PAYLOAD-1:0] req_payload,
  output logic                     req_err,
  output logic                     busy,
  output logic                     tx_valid,
  input  logic                     tx_ready,
  output logic [7:0]               tx_data
);

  tx_state_e       st_q;
  logic [IDXW-1:0] idx_q;
  logic [LENW-1:0] len_q;
  logic [7:0]      type_q;
  logic            len_ok, take, reject, fire, crc_en;
  logic [IDXW-1:0] rd_idx;
  logic [7:0]      rd_byte, crc_q, crc_nx;

  assign req_ready = ~busy;
  assign len_ok    = (req_len <= LENW'(MAX_PAYLOAD));
  assign take      = req_valid && !busy && len_ok;
  assign reject    = req_valid && !busy && !len_ok;
  assign fire      = tx_valid && tx_ready;
  assign crc_en    = fire && (st_q == ST_LEN || st_q == ST_TYPE || st_q == ST_PAY);
  assign rd_idx    = (st_q == ST_TYPE) ? '0 : idx_q + 1'b1;

  pkt_payload_buf #(.MAX_BYTES(MAX_PAYLOAD)) u_buf (
    .clk     (clk),
    .wr_en   (take),
    .be16    (req_be16),
    .din     (req_payload),
    .rd_idx  (rd_idx),
    .rd_byte (rd_byte)
  );

  pkt_crc8 u_crc (
    .clk    (clk),
    .rst    (rst),
    .clr    (take),
    .en     (crc_en),
    .din    (tx_data),
    .crc_q  (crc_q),
    .crc_nx (crc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      busy     <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
      req_err  <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
      type_q   <= 8'h00;
    end else begin
      req_err <= reject;
      case (st_q)
        ST_IDLE: if (take) begin
          st_q     <= ST_SYNC;
          busy     <= 1'b1;
          tx_valid <= 1'b1;
          tx_data  <= SYNC_BYTE;
          len_q    <= req_len;
          type_q   <= req_type;
        end
        ST_SYNC: if (fire) begin
          st_q    <= ST_LEN;
          tx_data <= len_q;
        end
        ST_LEN: if (fire) begin
          st_q    <= ST_TYPE;
          tx_data <= type_q;
        end
        ST_TYPE: if (fire) begin
          idx_q <= '0;
          if (len_q == '0) begin
            st_q    <= ST_CRC;
            tx_data <= crc_nx;
          end else begin
            st_q    <= ST_PAY;
            tx_data <= rd_byte;
          end
        end
        ST_PAY: if (fire) begin
          if (LENW'(idx_q) == len_q - 1'b1) begin
            st_q    <= ST_CRC;
            tx_data <= crc_nx;
          end else begin
            idx_q   <= idx_q + 1'b1;
            tx_data <= rd_byte;
          end
        end
        ST_CRC: if (fire) begin
          st_q     <= ST_IDLE;
          busy     <= 1'b0;
          tx_valid <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // byte counter kept only for the frame-length check
  logic [LENW:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (rst || take) chk_cnt <= '0;
    else if (fire)   chk_cnt <= chk_cnt + 1'b1;
  end

  a_r2_frame_len: assert property (@(posedge clk) disable iff (rst)
    (fire && st_q == ST_CRC) |-> (chk_cnt == {1'b0, len_q} + 3));

  a_r2_sync_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (tx_valid && tx_data == SYNC_BYTE));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r5_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!busy && !tx_valid));

  a_r7_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !tx_valid);

endmodule

// File: tb/pkt_frame_tx_tb.sv
module pkt_frame_tx_tb;

  localparam int MAXP = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [7:0]        req_type = 8'h00;
  logic [7:0]        req_len = 8'h00;
  logic              req_be16 = 1'b0;
  logic [8*MAXP-1:0] req_payload = '0;
  logic              req_err, busy, tx_valid;
  logic              tx_ready = 1'b0;
  logic [7:0]        tx_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pkt_frame_tx #(.MAX_PAYLOAD(MAXP)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_len(req_len), .req_be16(req_be16),
    .req_payload(req_payload), .req_err(req_err), .busy(busy),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int b = 0; b < 8; b++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic t_reset();
    check(!tx_valid && !busy && !req_err && req_ready, "R1 reset state",
          {tx_valid, busy, req_err, req_ready}, 4'b0001);
  endtask

  task automatic t_ref_crc();
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 9; i++) c = ref_step(c, 8'h31 + 8'(i));
    check(c == 8'hF4, "R3 reference model check", c, 8'hF4);
  endtask

  task automatic t_frame(input logic [7:0] typ, input int len, input logic [8*MAXP-1:0] pl,
                         input logic be, input logic stall, input logic poke, input string tag);
    logic [7:0] exp [MAXP+4];
    logic [7:0] rx  [MAXP+4];
    logic [7:0] c, held;
    logic       was_stalled, stab_ok, err_seen;
    int         got, cyc;
    exp[0] = 8'hAA; exp[1] = 8'(len); exp[2] = typ;
    for (int i = 0; i < len; i++) exp[3+i] = be ? pl[8*(i^1) +: 8] : pl[8*i +: 8];
    c = 8'h00;
    for (int i = 1; i < len + 3; i++) c = ref_step(c, exp[i]);
    exp[len+3] = c;
    for (int i = 0; i < MAXP + 4; i++) rx[i] = 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_type = typ; req_len = 8'(len); req_be16 = be; req_payload = pl;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, {tag, " R7 busy after accept"}, busy, 1);
    got = 0; cyc = 0; was_stalled = 1'b0; stab_ok = 1'b1; err_seen = 1'b0;
    while (got < len + 4 && cyc < 2000) begin
      tx_ready = stall ? (cyc % 3 == 2) : 1'b1;
      if (poke && cyc == 3) begin
        req_valid = 1'b1; req_type = 8'h55; req_len = 8'd1; req_payload = '1;
      end else if (poke && cyc == 4) begin
        req_valid = 1'b1; req_len = 8'(MAXP + 3);
      end else begin
        req_valid = 1'b0;
      end
      #1;
      if (was_stalled && (!tx_valid || tx_data != held)) stab_ok = 1'b0;
      if (req_err) err_seen = 1'b1;
      was_stalled = 1'b0;
      if (tx_valid && tx_ready) begin
        rx[got] = tx_data;
        got++;
      end else if (tx_valid) begin
        held = tx_data;
        was_stalled = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    tx_ready = 1'b0;
    req_valid = 1'b0;
    check(got == len + 4, {tag, " R2 frame length"}, got, len + 4);
    begin
      int bad_i = -1;
      for (int i = 0; i < len + 3; i++) if (bad_i < 0 && rx[i] != exp[i]) bad_i = i;
      check(bad_i < 0, {tag, be ? " R8 header/payload bytes" : " R2 header/payload bytes"},
            (bad_i < 0) ? 0 : rx[bad_i], (bad_i < 0) ? 0 : exp[bad_i]);
    end
    check(rx[len+3] == exp[len+3], {tag, " R3 crc byte"}, rx[len+3], exp[len+3]);
    check(!busy && !tx_valid && req_ready, {tag, " R7 idle after crc"}, busy, 0);
    if (stall) check(stab_ok, {tag, " R6 data held during stall"}, stab_ok, 1);
    if (poke)  check(!err_seen, {tag, " R7 request while busy ignored"}, err_seen, 0);
  endtask

  task automatic t_oversize();
    @(negedge clk);
    req_valid = 1'b1; req_len = 8'(MAXP + 1); req_type = 8'h22; req_payload = '1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_err && !tx_valid && !busy, "R5 oversize strobe", {req_err, tx_valid, busy}, 3'b100);
    @(negedge clk);
    check(!req_err && !tx_valid && !busy, "R5 strobe one cycle, nothing sent",
          {req_err, tx_valid, busy}, 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [8*MAXP-1:0] pl;
    for (int i = 0; i < MAXP; i++) pl[8*i +: 8] = 8'(8'h10 + 8'(i * 7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ref_crc();
    t_frame(8'h03, 3, pl, 1'b0, 1'b0, 1'b0, "basic");
    t_frame(8'h01, 0, pl, 1'b0, 1'b0, 1'b0, "R4 empty");
    t_frame(8'h02, 0, pl, 1'b0, 1'b1, 1'b0, "R4 empty stalled");
    t_frame(8'h7E, MAXP, pl, 1'b0, 1'b1, 1'b0, "R9 max stalled");
    t_frame(8'h41, 6, pl, 1'b1, 1'b0, 1'b0, "R8 be16 even");
    t_frame(8'h42, 5, pl, 1'b1, 1'b1, 1'b0, "R8 be16 odd");
    t_frame(8'h09, 4, pl, 1'b0, 1'b0, 1'b1, "R7 poke");
    t_oversize();
    t_frame(8'hC3, 2, ~pl, 1'b0, 1'b0, 1'b0, "after reject");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule